// File: doc/BRIEF.md
# Reset Pin Mode Controller

This block decides how a shared, bidirectional reset pin relates to the system reset of the chip. A two-bit configuration field selects one of three roles for the pin. In the first role the pin is an input that can only reset the chip. In the second it is a plain GPIO with no part in reset. In the third it is both an input and an open-drain output. The block synchronizes the pin level before using it. It drives internal reset requests out onto the pin when the mode allows it, and it produces a stretched system reset.

Internal resets reach the pin in one of two ways, chosen by a holder bit. With the holder off, the block drives a pulse of fixed length. With the holder on, it keeps pulling the pin low until the synchronized pin level reads back low. A timeout releases a hold that never sees the pin go low, and that event sets a sticky error flag. All state clears asynchronously on an active-low power-on reset.

Top module: `reset_pin_arbiter`

## Requirements
- R1: pinMode is decoded as 2'b01 input-only, 2'b10 GPIO, 2'b11 bidirectional, and the reserved 2'b00 behaves exactly like 2'b11. gpioMode is high, combinationally, only when pinMode is 2'b10.
- R2: In input-only mode, pinPullLow never rises, even while intRstReq is high. A low pin still raises sysRst.
- R3: In GPIO mode, pinPullLow never rises and the pin level has no effect on sysRst. intRstReq still raises sysRst.
- R4: In bidirectional mode, a low pin raises sysRst, and intRstReq is driven out onto the pin.
- R5: With holdEn=0, a request seen at a clock edge makes pinPullLow high from that edge for exactly PULSE_CYCLES (20) cycles. This holds even if the request drops early. A request that stays high produces only one pulse.
- R6: With holdEn=1, pinPullLow rises at the edge that samples the request. It falls at the first edge at which the synchronized pin reads low. When the pin follows the drive, that gives 3 cycles of drive.
- R7: If a hold never sees the pin low, pinPullLow is released after exactly HOLD_TIMEOUT (1024) cycles and holdTimeoutErr is set. holdTimeoutErr then stays high until power-on reset.
- R8: The pin passes through two synchronizer flops. A low pin that is applied between edges raises sysRst after the third edge and not after the second.
- R9: sysRst is high while intRstReq is high or a qualified low pin is sampled. It then stays high for STRETCH_CYCLES (16) more cycles, and falls after the 17th edge that no longer sees a reset source.
- R10: While porRstN is low, pinPullLow, sysRst and holdTimeoutErr are 0. The clear is asynchronous.
- R11: When an external low overlaps an internal request, sysRst stays high without a gap until STRETCH_CYCLES cycles after the last source goes away.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| porRstN | input | 1 | Asynchronous active-low power-on reset |
| pinMode | input | 2 | Pin role selection (see R1) |
| holdEn | input | 1 | 1: hold the pin low until it reads low; 0: fixed pulse |
| intRstReq | input | 1 | Internal reset request, synchronous to clk |
| pinIn | input | 1 | Raw level read from the reset pin |
| pinPullLow | output | 1 | Open-drain pull-down enable for the pin |
| gpioMode | output | 1 | High when the pin is in GPIO mode |
| sysRst | output | 1 | Stretched system reset, active high |
| holdTimeoutErr | output | 1 | Sticky flag set when a hold times out |

## Verification
Timing is counted from the first clock edge after an input change. pinPullLow and sysRst respond to intRstReq after that first edge. A pin level reaches sysRst only after the third edge, and the fall of sysRst comes at the 17th edge without a source. Holder release comes three edges after the drive starts when the pin follows it, and after 1024 edges when the pin is stuck high. The bench drives and samples 1 ns after each rising edge. It counts drive cycles over windows that are longer than any expected pulse, and it tests sysRst at the exact edges on both sides of each transition.

// File: rtl/rstpin_pkg.sv
package rstpin_pkg;

  typedef enum logic [1:0] {
    PM_RSVD  = 2'b00,
    PM_INPUT = 2'b01,
    PM_GPIO  = 2'b10,
    PM_BIDIR = 2'b11
  } pinMode_e;

  typedef enum logic [1:0] {
    DR_IDLE,
    DR_PULSE,
    DR_HOLD,
    DR_WAIT
  } drvState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic errSet;
    logic rstSrc;
  } dpStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic pinLow;
    logic pulseDone;
    logic holdExpired;
  } dpStatus_t;

endpackage

// File: rtl/rstpin_dp.sv
module rstpin_dp
  import rstpin_pkg::*;
#(
  parameter int PULSE_CYCLES   = 20,
  parameter int HOLD_TIMEOUT   = 1024,
  parameter int STRETCH_CYCLES = 16,
  parameter int SYNC_STAGES    = 2
) (
  input  logic      clk,
  input  logic      porRstN,
  input  logic      pinIn,
  input  dpStrobe_t strobe,
  output dpStatus_t status,
  output logic      sysRst,
  output logic      holdTimeoutErr
);

  localparam int CNT_MAX = (HOLD_TIMEOUT > PULSE_CYCLES) ? HOLD_TIMEOUT : PULSE_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX);
  localparam int STR_W   = $clog2(STRETCH_CYCLES + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CNT_W-1:0]       drvCnt;
  logic [STR_W-1:0]       stretchCnt;
  logic                   sysRstQ;
  logic                   errQ;

  // pin synchronizer, idles at the released (high) level
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) syncQ <= '1;
    else          syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
  end

  // shared drive counter for pulse length and hold timeout
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)          drvCnt <= '0;
    else if (strobe.cntClr) drvCnt <= '0;
    else if (strobe.cntInc) drvCnt <= drvCnt + 1'b1;
  end

  // reset stretcher
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      stretchCnt <= '0;
      sysRstQ    <= 1'b0;
    end else if (strobe.rstSrc) begin
      stretchCnt <= STR_W'(STRETCH_CYCLES);
      sysRstQ    <= 1'b1;
    end else if (stretchCnt != '0) begin
      stretchCnt <= stretchCnt - 1'b1;
      sysRstQ    <= 1'b1;
    end else begin
      sysRstQ    <= 1'b0;
    end
  end

  // sticky timeout flag
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)          errQ <= 1'b0;
    else if (strobe.errSet) errQ <= 1'b1;
  end

  always_comb begin
    status.pinLow      = ~syncQ[SYNC_STAGES-1];
    status.pulseDone   = (drvCnt == CNT_W'(PULSE_CYCLES - 1));
    status.holdExpired = (drvCnt == CNT_W'(HOLD_TIMEOUT - 1));
  end

  assign sysRst         = sysRstQ;
  assign holdTimeoutErr = errQ;

endmodule

// File: rtl/rstpin_ctrl.sv
module rstpin_ctrl
  import rstpin_pkg::*;
(
  input  logic       clk,
  input  logic       porRstN,
  input  logic [1:0] pinMode,
  input  logic       holdEn,
  input  logic       intRstReq,
  input  dpStatus_t  status,
  output dpStrobe_t  strobe,
  output logic       pinPullLow,
  output logic       gpioMode
);

  drvState_e state, stateNxt;
  pinMode_e  modeSel;
  logic      extEn;
  logic      driveEn;

  // mode decode; reserved code folds into bidirectional
  always_comb begin
    modeSel = pinMode_e'(pinMode);
    unique case (modeSel)
      PM_INPUT: begin extEn = 1'b1; driveEn = 1'b0; end
      PM_GPIO:  begin extEn = 1'b0; driveEn = 1'b0; end
      default:  begin extEn = 1'b1; driveEn = 1'b1; end
    endcase
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) state <= DR_IDLE;
    else          state <= stateNxt;
  end

  always_comb begin
    stateNxt      = state;
    strobe.cntClr = 1'b0;
    strobe.cntInc = 1'b0;
    strobe.errSet = 1'b0;
    strobe.rstSrc = intRstReq | (extEn & status.pinLow);
    case (state)
      DR_IDLE: begin
        if (intRstReq && driveEn) begin
          stateNxt      = holdEn ? DR_HOLD : DR_PULSE;
          strobe.cntClr = 1'b1;
        end
      end
      DR_PULSE: begin
        if (!driveEn || status.pulseDone) stateNxt = DR_WAIT;
        else                              strobe.cntInc = 1'b1;
      end
      DR_HOLD: begin
        if (!driveEn || status.pinLow) begin
          stateNxt = DR_WAIT;
        end else if (status.holdExpired) begin
          stateNxt      = DR_WAIT;
          strobe.errSet = 1'b1;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      DR_WAIT: begin
        if (!intRstReq) stateNxt = DR_IDLE;
      end
      default: stateNxt = DR_IDLE;
    endcase
  end

  assign pinPullLow = driveEn & ((state == DR_PULSE) | (state == DR_HOLD));
  assign gpioMode   = (modeSel == PM_GPIO);

endmodule

// File: rtl/reset_pin_arbiter.sv
module reset_pin_arbiter
  import rstpin_pkg::*;
#(
  parameter int PULSE_CYCLES   = 20,
  parameter int HOLD_TIMEOUT   = 1024,
  parameter int STRETCH_CYCLES = 16,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       porRstN,
  input  logic [1:0] pinMode,
  input  logic       holdEn,
  input  logic       intRstReq,
  input  logic       pinIn,
  output logic       pinPullLow,
  output logic       gpioMode,
  output logic       sysRst,
  output logic       holdTimeoutErr
);

  dpStrobe_t strobe;
  dpStatus_t status;

  rstpin_ctrl u_ctrl (
    .clk        (clk),
    .porRstN    (porRstN),
    .pinMode    (pinMode),
    .holdEn     (holdEn),
    .intRstReq  (intRstReq),
    .status     (status),
    .strobe     (strobe),
    .pinPullLow (pinPullLow),
    .gpioMode   (gpioMode)
  );

  rstpin_dp #(
    .PULSE_CYCLES   (PULSE_CYCLES),
    .HOLD_TIMEOUT   (HOLD_TIMEOUT),
    .STRETCH_CYCLES (STRETCH_CYCLES),
    .SYNC_STAGES    (SYNC_STAGES)
  ) u_dp (
    .clk            (clk),
    .porRstN        (porRstN),
    .pinIn          (pinIn),
    .strobe         (strobe),
    .status         (status),
    .sysRst         (sysRst),
    .holdTimeoutErr (holdTimeoutErr)
  );

endmodule

// File: rtl/reset_pin_arbiter_chk.sv
module reset_pin_arbiter_chk #(
  parameter int PULSE_CYCLES = 20,
  parameter int HOLD_TIMEOUT = 1024
) (
  input logic       clk,
  input logic       porRstN,
  input logic [1:0] pinMode,
  input logic       intRstReq,
  input logic       pinPullLow,
  input logic       sysRst,
  input logic       holdTimeoutErr
);

  localparam int RUN_LIMIT = (HOLD_TIMEOUT > PULSE_CYCLES) ? HOLD_TIMEOUT : PULSE_CYCLES;

  int runLen;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)        runLen <= 0;
    else if (pinPullLow) runLen <= (runLen > RUN_LIMIT) ? runLen : runLen + 1;
    else                 runLen <= 0;
  end

  p_gpio_no_drive_r3: assert property (@(posedge clk) disable iff (!porRstN)
    (pinMode == 2'b10) |-> !pinPullLow);

  p_input_no_drive_r2: assert property (@(posedge clk) disable iff (!porRstN)
    (pinMode == 2'b01) |-> !pinPullLow);

  p_req_raises_rst_r9: assert property (@(posedge clk) disable iff (!porRstN)
    intRstReq |=> sysRst);

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!porRstN)
    holdTimeoutErr |=> holdTimeoutErr);

  p_drive_bounded_r7: assert property (@(posedge clk) disable iff (!porRstN)
    runLen <= RUN_LIMIT);

endmodule

bind reset_pin_arbiter reset_pin_arbiter_chk #(
  .PULSE_CYCLES (PULSE_CYCLES),
  .HOLD_TIMEOUT (HOLD_TIMEOUT)
) u_chk (
  .clk            (clk),
  .porRstN        (porRstN),
  .pinMode        (pinMode),
  .intRstReq      (intRstReq),
  .pinPullLow     (pinPullLow),
  .sysRst         (sysRst),
  .holdTimeoutErr (holdTimeoutErr)
);

// File: tb/tb_reset_pin_arbiter.sv
module tb_reset_pin_arbiter;

  localparam int P = 20;
  localparam int T = 1024;
  localparam int S = 16;

  logic       clk = 1'b0;
  logic       porRstN = 1'b1;
  logic [1:0] pinMode = 2'b11;
  logic       holdEn = 1'b0;
  logic       intRstReq = 1'b0;
  logic       extLow = 1'b0;
  logic       stuckHigh = 1'b0;
  logic       pinIn;
  logic       pinPullLow, gpioMode, sysRst, holdTimeoutErr;

  int nRun = 0;
  int nFail = 0;
  int cyc = 0;

  // pin model: open-drain wire with external pull-up
  assign pinIn = stuckHigh ? 1'b1 : ~(pinPullLow | extLow);

  always #2 clk = ~clk;

  reset_pin_arbiter dut (
    .clk            (clk),
    .porRstN        (porRstN),
    .pinMode        (pinMode),
    .holdEn         (holdEn),
    .intRstReq      (intRstReq),
    .pinIn          (pinIn),
    .pinPullLow     (pinPullLow),
    .gpioMode       (gpioMode),
    .sysRst         (sysRst),
    .holdTimeoutErr (holdTimeoutErr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp, input string what);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic countDrive(input int n, output int c);
    c = 0;
    for (int k = 0; k < n; k++) begin
      step(1);
      if (pinPullLow) c++;
    end
  endtask

  // drop request, then sysRst must hold 16 cycles and fall at the 17th edge
  task automatic dropAndStretch(input string tag);
    intRstReq = 1'b0;
    step(S);
    chk(sysRst == 1'b1, tag, sysRst, 1, "sysRst at last stretch cycle");
    step(1);
    chk(sysRst == 1'b0, tag, sysRst, 0, "sysRst after stretch");
  endtask

  task automatic tReset();
    #1 porRstN = 1'b0;
    #4;
    chk(pinPullLow == 1'b0 && sysRst == 1'b0 && holdTimeoutErr == 1'b0, "R10",
        {pinPullLow, sysRst, holdTimeoutErr}, 0, "outputs in power-on reset");
    @(posedge clk); #1 porRstN = 1'b1;
    step(3);
  endtask

  task automatic tPulse();
    int c;
    pinMode = 2'b11; holdEn = 1'b0;
    intRstReq = 1'b1;
    step(1);
    chk(pinPullLow == 1'b1, "R4", pinPullLow, 1, "bidir drive starts after first edge");
    chk(sysRst == 1'b1, "R9", sysRst, 1, "sysRst after request edge");
    countDrive(29, c);
    chk(c == P - 1, "R5", c + 1, P, "pulse length with held request");
    dropAndStretch("R9");
    step(10);
    // short request: pulse still full length
    intRstReq = 1'b1;
    step(2);
    intRstReq = 1'b0;
    countDrive(30, c);
    chk(c == P - 2, "R5", c + 2, P, "pulse length with short request");
    step(40);
  endtask

  task automatic tHold();
    int c;
    pinMode = 2'b11; holdEn = 1'b1;
    intRstReq = 1'b1;
    countDrive(10, c);
    chk(c == 3, "R6", c, 3, "holder drive cycles with pin following");
    chk(holdTimeoutErr == 1'b0, "R6", holdTimeoutErr, 0, "no timeout on normal hold");
    intRstReq = 1'b0;
    step(40);
  endtask

  task automatic tTimeout();
    int c;
    pinMode = 2'b11; holdEn = 1'b1; stuckHigh = 1'b1;
    intRstReq = 1'b1;
    countDrive(T + 10, c);
    chk(c == T, "R7", c, T, "hold released by timeout");
    chk(holdTimeoutErr == 1'b1, "R7", holdTimeoutErr, 1, "timeout flag set");
    intRstReq = 1'b0; stuckHigh = 1'b0;
    step(40);
    chk(holdTimeoutErr == 1'b1, "R7", holdTimeoutErr, 1, "timeout flag sticky");
  endtask

  task automatic tPor();
    holdEn = 1'b0; pinMode = 2'b11;
    intRstReq = 1'b1;
    step(3);
    porRstN = 1'b0;
    #1;
    chk(pinPullLow == 1'b0 && sysRst == 1'b0 && holdTimeoutErr == 1'b0, "R10",
        {pinPullLow, sysRst, holdTimeoutErr}, 0, "asynchronous clear mid-drive");
    intRstReq = 1'b0;
    step(2);
    porRstN = 1'b1;
    step(3);
    chk(sysRst == 1'b0 && holdTimeoutErr == 1'b0, "R10", {sysRst, holdTimeoutErr}, 0, "quiet after reset");
  endtask

  task automatic tInputOnly();
    int c;
    pinMode = 2'b01; holdEn = 1'b0;
    intRstReq = 1'b1;
    countDrive(25, c);
    chk(c == 0, "R2", c, 0, "no drive in input-only mode");
    chk(sysRst == 1'b1, "R2", sysRst, 1, "internal reset in input-only mode");
    intRstReq = 1'b0;
    step(20);
    extLow = 1'b1;
    step(2);
    chk(sysRst == 1'b0, "R8", sysRst, 0, "pin low not yet through synchronizer");
    step(1);
    chk(sysRst == 1'b1, "R8", sysRst, 1, "pin low after third edge");
    step(10);
    extLow = 1'b0;
    step(18);
    chk(sysRst == 1'b1, "R9", sysRst, 1, "stretch after pin release");
    step(1);
    chk(sysRst == 1'b0, "R9", sysRst, 0, "sysRst falls after pin stretch");
  endtask

  task automatic tGpio();
    int c;
    int bad;
    pinMode = 2'b10; holdEn = 1'b0;
    #1;
    chk(gpioMode == 1'b1, "R1", gpioMode, 1, "gpioMode flag for code 2");
    extLow = 1'b1;
    bad = 0;
    for (int k = 0; k < 10; k++) begin
      step(1);
      if (sysRst) bad++;
    end
    chk(bad == 0, "R3", bad, 0, "pin ignored in GPIO mode");
    extLow = 1'b0;
    intRstReq = 1'b1;
    countDrive(25, c);
    chk(c == 0, "R3", c, 0, "no drive in GPIO mode");
    chk(sysRst == 1'b1, "R3", sysRst, 1, "internal reset in GPIO mode");
    intRstReq = 1'b0;
    step(20);
  endtask

  task automatic tReserved();
    int c;
    pinMode = 2'b00; holdEn = 1'b0;
    #1;
    chk(gpioMode == 1'b0, "R1", gpioMode, 0, "gpioMode flag for reserved code");
    intRstReq = 1'b1;
    countDrive(30, c);
    chk(c == P, "R1", c, P, "reserved code drives like bidirectional");
    intRstReq = 1'b0;
    step(40);
  endtask

  task automatic tOverlap();
    int bad;
    pinMode = 2'b11; holdEn = 1'b0;
    extLow = 1'b1;
    step(3);
    chk(sysRst == 1'b1, "R4", sysRst, 1, "external low resets in bidir mode");
    bad = 0;
    step(2);
    if (!sysRst) bad++;
    intRstReq = 1'b1;
    for (int k = 0; k < 5; k++) begin step(1); if (!sysRst) bad++; end
    extLow = 1'b0;
    for (int k = 0; k < 30; k++) begin step(1); if (!sysRst) bad++; end
    chk(bad == 0, "R11", bad, 0, "gaps in sysRst during overlap");
    dropAndStretch("R11");
  endtask

  initial begin
    tReset();
    tPulse();
    tHold();
    tTimeout();
    tPor();
    tInputOnly();
    tGpio();
    tReserved();
    tOverlap();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        nRun++;
        nFail++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 20000);
        $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
        $finish;
      end
    end
  end

endmodule